// File: doc/BRIEF.md
# DMA Channel Control Register Bank

This block is the software-visible control surface for every channel of a descriptor-driven DMA engine. A 32-bit word-access bus reads and writes it. Each channel has its own bank of registers: five descriptor pointers, a command word, a configuration word, a stream command, an interrupt mask, a write-only acknowledge, and the raw and masked interrupt words. The descriptor fetcher and the data mover sit outside the block. They tell it about start requests, end-of-list, stream-command source changes and interrupt events through side inputs. The block gives back the channel state, an enable flag, strobes for command writes and one level interrupt line per channel.

Each channel runs a three-state machine. RESET (code 1) is entered from any state when the configuration is written with bit 0 clear. HALTED (code 2) is entered from any state when the configuration is written with bit 0 and bit 1 both set. ACTIVE (code 4) is entered from RESET or HALTED when the engine requests a start while the channel is enabled and not halted. A configuration write with bit 0 set and bit 1 clear leaves the state where it is. A configuration write in the same cycle as a start request takes precedence over the start. A status read combines the state code, the end-of-list flag and the stream-command source into one word.

Top module: `dmac_ctrl_regs`

## Requirements
- R1: The channel is selected by address bits 13 and up, and the register index by address bits [7:2]. Bits [12:8] and [1:0] are ignored. A write to one channel changes no register and no output of another channel.
- R2: After reset, every register reads zero, except the status word, which reads 0x101. The state is RESET, and irq and the strobes are low.
- R3: The configuration word sits at index 33 (byte 0x84) and reads back as written. A write with bit 0 clear puts the state in RESET, even when bit 1 is set. A write with bits 0 and 1 both set puts it in HALTED. A write with bit 0 set and bit 1 clear leaves the state unchanged. The state is always one-hot.
- R4: A start request pulse moves the state to ACTIVE one cycle later, but only when configuration bit 0 is set, the client is present and configuration bit 1 is clear. Otherwise the state does not change. chan_enabled is configuration bit 0 AND client_present.
- R5: An eol_set pulse sets the end-of-list flag. An accepted start clears it, and eol_set wins if both occur in the same cycle. A src_load pulse loads src_value as the stream-command source, which resets to 1.
- R6: The status word sits at index 34 (byte 0x88). Bits [2:0] hold the state code, bit 5 holds end-of-list, and bits [8+SRC_W-1:8] hold the stream-command source. All other bits are zero, and writes to the status word have no effect.
- R7: A write to the acknowledge word (index 36, byte 0x90) clears the written ones from the raw interrupt word (index 37, byte 0x94) in the next cycle. The acknowledge word always reads zero. An intr_set pulse on the same bit in the same cycle wins over the acknowledge.
- R8: The masked word (index 38, byte 0x98) equals raw AND mask, where the mask is at index 35 (byte 0x8C). irq is high exactly when the masked word is non-zero. Both follow a mask write, an acknowledge or a set pulse one cycle later.
- R9: intr_set pulses OR into the raw word. Writes to the raw and masked words have no effect.
- R10: The stream command word (index 39, byte 0x9C) keeps only the low 10 bits written. Each write to it raises scmd_strobe for exactly the following cycle.
- R11: The command word (index 32, byte 0x80) reads back as written. Each write to it raises cmd_strobe for exactly the following cycle.
- R12: The pointer words at indices 0, 22, 23, 24 and 31 (bytes 0x00, 0x58, 0x5C, 0x60, 0x7C) read back all 32 written bits. Every other index reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one word |
| bus_addr | input | 13+CH_W | Byte address: channel in the top bits, register index in [7:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| client_present | input | NUM_CH | A client is attached to each channel |
| start_req | input | NUM_CH | Engine start request pulse per channel |
| eol_set | input | NUM_CH | End-of-list reached pulse per channel |
| intr_set | input | NUM_CH*INTR_W | Raw interrupt set pulses, INTR_W per channel |
| src_load | input | NUM_CH | Load strobe for the stream-command source |
| src_value | input | NUM_CH*SRC_W | New stream-command source per channel |
| irq | output | NUM_CH | Level interrupt per channel |
| chan_state | output | NUM_CH*3 | One-hot state per channel |
| chan_enabled | output | NUM_CH | Channel enabled |
| cmd_strobe | output | NUM_CH | Command word written last cycle |
| scmd_strobe | output | NUM_CH | Stream command written last cycle |

## Verification
A wrong state register shows at chan_state and in status bits [2:0] on the cycle after the configuration write or start pulse that caused it. A wrong raw or mask value reaches irq and the masked word one cycle after the triggering event. This is why the bench sweeps every mask against every set pattern and then acknowledges a derived pattern. A decode fault shows up as a read-back mismatch, or as an effect on the other channel, right after the write. The bench therefore writes every index of both channels.

// File: rtl/dmac_regs_pkg.sv
package dmac_regs_pkg;

    typedef enum logic [2:0] {
        ST_RESET  = 3'b001,
        ST_HALTED = 3'b010,
        ST_ACTIVE = 3'b100
    } ch_state_e;

    localparam int IDX_W  = 6;
    localparam int SCMD_W = 10;
    localparam int N_PTR  = 5;

    localparam logic [IDX_W-1:0] IDX_CMD     = 6'd32;
    localparam logic [IDX_W-1:0] IDX_CFG     = 6'd33;
    localparam logic [IDX_W-1:0] IDX_STATUS  = 6'd34;
    localparam logic [IDX_W-1:0] IDX_IMASK   = 6'd35;
    localparam logic [IDX_W-1:0] IDX_IACK    = 6'd36;
    localparam logic [IDX_W-1:0] IDX_IRAW    = 6'd37;
    localparam logic [IDX_W-1:0] IDX_IMASKED = 6'd38;
    localparam logic [IDX_W-1:0] IDX_SCMD    = 6'd39;

    // descriptor pointer words: current data, saved data, saved buffer, group, group down
    localparam logic [N_PTR-1:0][IDX_W-1:0] PTR_IDX = {6'd31, 6'd24, 6'd23, 6'd22, 6'd0};

    typedef struct packed {
        logic             we;
        logic [IDX_W-1:0] idx;
        logic [31:0]      wdata;
    } reg_wr_t;

endpackage

// File: rtl/dmac_ch_fsm.sv
module dmac_ch_fsm
    import dmac_regs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_bits,
    input  logic       start_req,
    input  logic       enabled,
    input  logic       halted,
    input  logic       eol_set,
    output logic [2:0] state,
    output logic       eol_flag
);

    ch_state_e state_q, state_d;
    logic      eol_q, eol_d;
    logic      start_ok;

    assign start_ok = start_req && enabled && !halted && !cfg_we;

    always_comb begin
        state_d = state_q;
        if (cfg_we) begin
            if (!cfg_bits[0])
                state_d = ST_RESET;
            else if (cfg_bits[1])
                state_d = ST_HALTED;
        end else begin
            unique case (state_q)
                ST_RESET:  if (start_ok) state_d = ST_ACTIVE;
                ST_HALTED: if (start_ok) state_d = ST_ACTIVE;
                ST_ACTIVE: state_d = ST_ACTIVE;
                default:   state_d = ST_RESET;
            endcase
        end
    end

    always_comb begin
        eol_d = eol_q;
        if (start_ok)
            eol_d = 1'b0;
        if (eol_set)
            eol_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            eol_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            eol_q   <= eol_d;
        end
    end

    always_comb begin
        state    = state_q;
        eol_flag = eol_q;
    end

    p_state_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state_q));

    p_cfg_forces_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_bits[0]) |=> (state_q == ST_RESET));

    p_start_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && $past(state_q) != ST_ACTIVE) |-> $past(enabled && !halted && start_req));

endmodule

// File: rtl/dmac_ch_intr.sv
module dmac_ch_intr #(
    parameter int INTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              ack_we,
    input  logic [INTR_W-1:0] wbits,
    input  logic [INTR_W-1:0] set_pulse,
    output logic [INTR_W-1:0] raw,
    output logic [INTR_W-1:0] mask,
    output logic [INTR_W-1:0] masked,
    output logic              irq
);

    logic [INTR_W-1:0] raw_q, raw_d, mask_q, mask_d, masked_q;
    logic              irq_q;

    always_comb begin
        mask_d = mask_we ? wbits : mask_q;
        raw_d  = raw_q;
        if (ack_we)
            raw_d = raw_d & ~wbits;
        raw_d = raw_d | set_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw_q    <= '0;
            mask_q   <= '0;
            masked_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            raw_q    <= raw_d;
            mask_q   <= mask_d;
            masked_q <= raw_d & mask_d;
            irq_q    <= |(raw_d & mask_d);
        end
    end

    assign raw    = raw_q;
    assign mask   = mask_q;
    assign masked = masked_q;
    assign irq    = irq_q;

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_we |=> ((raw_q & $past(wbits & ~set_pulse)) == '0));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_pulse) |=> ((raw_q & $past(set_pulse)) == $past(set_pulse)));

    p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (|(raw_q & mask_q)));

endmodule

// File: rtl/dmac_ch_regs.sv
module dmac_ch_regs
    import dmac_regs_pkg::*;
#(
    parameter int INTR_W    = 4,
    parameter int SRC_W     = 4,
    parameter int SRC_RESET = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  reg_wr_t           wr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_data,
    input  logic              client_present,
    input  logic              start_req,
    input  logic              eol_set,
    input  logic [INTR_W-1:0] intr_set,
    input  logic              src_load,
    input  logic [SRC_W-1:0]  src_value,
    output logic              irq,
    output logic [2:0]        state,
    output logic              enabled,
    output logic              cmd_strobe,
    output logic              scmd_strobe
);

    logic [31:0]       cfg_q, cmd_q;
    logic [SCMD_W-1:0] scmd_q;
    logic [SRC_W-1:0]  src_q;
    logic              cmd_stb_q, scmd_stb_q;
    logic [N_PTR-1:0][31:0] ptr_q;
    logic [INTR_W-1:0] raw, mask, masked;
    logic              eol_flag;
    logic              cfg_we, cmd_we, scmd_we, mask_we, ack_we;

    assign cfg_we  = wr.we && (wr.idx == IDX_CFG);
    assign cmd_we  = wr.we && (wr.idx == IDX_CMD);
    assign scmd_we = wr.we && (wr.idx == IDX_SCMD);
    assign mask_we = wr.we && (wr.idx == IDX_IMASK);
    assign ack_we  = wr.we && (wr.idx == IDX_IACK);

    generate
        for (genvar p = 0; p < N_PTR; p++) begin : g_ptr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    ptr_q[p] <= '0;
                else if (wr.we && wr.idx == PTR_IDX[p])
                    ptr_q[p] <= wr.wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            cmd_q      <= '0;
            scmd_q     <= '0;
            src_q      <= SRC_W'(SRC_RESET);
            cmd_stb_q  <= 1'b0;
            scmd_stb_q <= 1'b0;
        end else begin
            if (cfg_we)  cfg_q  <= wr.wdata;
            if (cmd_we)  cmd_q  <= wr.wdata;
            if (scmd_we) scmd_q <= wr.wdata[SCMD_W-1:0];
            if (src_load) src_q <= src_value;
            cmd_stb_q  <= cmd_we;
            scmd_stb_q <= scmd_we;
        end
    end

    assign enabled     = cfg_q[0] && client_present;
    assign cmd_strobe  = cmd_stb_q;
    assign scmd_strobe = scmd_stb_q;

    dmac_ch_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_bits  (wr.wdata[1:0]),
        .start_req (start_req),
        .enabled   (enabled),
        .halted    (cfg_q[1]),
        .eol_set   (eol_set),
        .state     (state),
        .eol_flag  (eol_flag)
    );

    dmac_ch_intr #(.INTR_W(INTR_W)) u_intr (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (mask_we),
        .ack_we    (ack_we),
        .wbits     (wr.wdata[INTR_W-1:0]),
        .set_pulse (intr_set),
        .raw       (raw),
        .mask      (mask),
        .masked    (masked),
        .irq       (irq)
    );

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            PTR_IDX[0]:  rd_data = ptr_q[0];
            PTR_IDX[1]:  rd_data = ptr_q[1];
            PTR_IDX[2]:  rd_data = ptr_q[2];
            PTR_IDX[3]:  rd_data = ptr_q[3];
            PTR_IDX[4]:  rd_data = ptr_q[4];
            IDX_CMD:     rd_data = cmd_q;
            IDX_CFG:     rd_data = cfg_q;
            IDX_STATUS: begin
                rd_data[2:0]         = state;
                rd_data[5]           = eol_flag;
                rd_data[8 +: SRC_W]  = src_q;
            end
            IDX_IMASK:   rd_data = 32'(mask);
            IDX_IRAW:    rd_data = 32'(raw);
            IDX_IMASKED: rd_data = 32'(masked);
            IDX_SCMD:    rd_data = 32'(scmd_q);
            default:     rd_data = '0;
        endcase
    end

    p_cmd_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_we |=> cmd_strobe);

    p_scmd_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !scmd_we |=> !scmd_strobe);

endmodule

// File: rtl/dmac_ctrl_regs.sv
module dmac_ctrl_regs
    import dmac_regs_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int INTR_W = 4,
    parameter int SRC_W  = 4,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = 13 + CH_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [NUM_CH-1:0]          client_present,
    input  logic [NUM_CH-1:0]          start_req,
    input  logic [NUM_CH-1:0]          eol_set,
    input  logic [NUM_CH*INTR_W-1:0]   intr_set,
    input  logic [NUM_CH-1:0]          src_load,
    input  logic [NUM_CH*SRC_W-1:0]    src_value,
    output logic [NUM_CH-1:0]          irq,
    output logic [NUM_CH*3-1:0]        chan_state,
    output logic [NUM_CH-1:0]          chan_enabled,
    output logic [NUM_CH-1:0]          cmd_strobe,
    output logic [NUM_CH-1:0]          scmd_strobe
);

    logic [CH_W-1:0]  ch_sel;
    logic [IDX_W-1:0] idx;
    logic [31:0]      rd_arr [NUM_CH];
    logic             unused_addr_bits;

    assign ch_sel           = bus_addr[ADDR_W-1:13];
    assign idx              = bus_addr[7:2];
    assign unused_addr_bits = ^{bus_addr[12:8], bus_addr[1:0]};

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            reg_wr_t wr_g;
            assign wr_g.we    = bus_wr && (int'(ch_sel) == g);
            assign wr_g.idx   = idx;
            assign wr_g.wdata = bus_wdata;

            dmac_ch_regs #(.INTR_W(INTR_W), .SRC_W(SRC_W)) u_ch (
                .clk            (clk),
                .rst_n          (rst_n),
                .wr             (wr_g),
                .rd_idx         (idx),
                .rd_data        (rd_arr[g]),
                .client_present (client_present[g]),
                .start_req      (start_req[g]),
                .eol_set        (eol_set[g]),
                .intr_set       (intr_set[g*INTR_W +: INTR_W]),
                .src_load       (src_load[g]),
                .src_value      (src_value[g*SRC_W +: SRC_W]),
                .irq            (irq[g]),
                .state          (chan_state[g*3 +: 3]),
                .enabled        (chan_enabled[g]),
                .cmd_strobe     (cmd_strobe[g]),
                .scmd_strobe    (scmd_strobe[g])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (int'(ch_sel) == c)
                bus_rdata = rd_arr[c];
    end

endmodule

// File: tb/tb_dmac_ctrl_regs.sv
module tb_dmac_ctrl_regs;

    localparam int NUM_CH = 2;
    localparam int INTR_W = 4;
    localparam int SRC_W  = 4;
    localparam int ADDR_W = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NUM_CH-1:0] client_present = '0;
    logic [NUM_CH-1:0] start_req = '0;
    logic [NUM_CH-1:0] eol_set = '0;
    logic [NUM_CH*INTR_W-1:0] intr_set = '0;
    logic [NUM_CH-1:0] src_load = '0;
    logic [NUM_CH*SRC_W-1:0] src_value = '0;
    logic [NUM_CH-1:0] irq;
    logic [NUM_CH*3-1:0] chan_state;
    logic [NUM_CH-1:0] chan_enabled, cmd_strobe, scmd_strobe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dmac_ctrl_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .client_present(client_present), .start_req(start_req), .eol_set(eol_set),
        .intr_set(intr_set), .src_load(src_load), .src_value(src_value),
        .irq(irq), .chan_state(chan_state), .chan_enabled(chan_enabled),
        .cmd_strobe(cmd_strobe), .scmd_strobe(scmd_strobe)
    );

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(int ch, int idx, int alias_bits);
        return ADDR_W'((ch << 13) | ((alias_bits & 31) << 8) | (idx << 2));
    endfunction

    task automatic wr(int ch, int idx, logic [31:0] d, int alias_bits = 0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = mk_addr(ch, idx, alias_bits); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(int ch, int idx, output logic [31:0] d);
        bus_addr = mk_addr(ch, idx, 0);
        #1;
        d = bus_rdata;
    endtask

    task automatic rdchk(string req, int ch, int idx, logic [31:0] exp);
        logic [31:0] v;
        rd(ch, idx, v);
        chk(req, v, exp);
    endtask

    task automatic pulse_start(int ch);
        @(negedge clk); start_req[ch] = 1'b1;
        @(negedge clk); start_req[ch] = 1'b0;
    endtask

    task automatic pulse_set(int ch, logic [INTR_W-1:0] s);
        @(negedge clk); intr_set[ch*INTR_W +: INTR_W] = s;
        @(negedge clk); intr_set = '0;
    endtask

    function automatic bit is_listed(int idx);
        return idx == 0 || idx == 22 || idx == 23 || idx == 24 || idx == 31 ||
               (idx >= 32 && idx <= 39);
    endfunction

    function automatic logic [31:0] pat(int ch, int idx);
        return 32'hA5000000 ^ (32'(ch) << 20) ^ (32'(idx) * 32'h01010101);
    endfunction

    function automatic logic [31:0] stat(int st, int eol, int src);
        return 32'(st) | (32'(eol) << 5) | (32'(src) << 8);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset values on every index of both channels
        for (int c = 0; c < NUM_CH; c++)
            for (int i = 0; i < 64; i++)
                rdchk("R2 reset value", c, i, (i == 34) ? 32'h101 : 32'h0);
        chk("R2 irq low", 32'(irq), 0);
        chk("R2 state reset", 32'(chan_state), 32'h9);
        chk("R2 strobes low", 32'({cmd_strobe, scmd_strobe}), 0);

        // R12: pointer words keep 32 bits; R1 alias bits ignored
        for (int c = 0; c < NUM_CH; c++) begin
            wr(c, 0, pat(c, 0));
            wr(c, 22, pat(c, 22));
            wr(c, 23, pat(c, 23), 5);
            wr(c, 24, pat(c, 24), 31);
            wr(c, 31, pat(c, 31));
        end
        for (int c = 0; c < NUM_CH; c++) begin
            rdchk("R12 pointer 0", c, 0, pat(c, 0));
            rdchk("R12 pointer 22", c, 22, pat(c, 22));
            rdchk("R1 alias pointer 23", c, 23, pat(c, 23));
            rdchk("R1 alias pointer 24", c, 24, pat(c, 24));
            rdchk("R12 pointer 31", c, 31, pat(c, 31));
        end
        // R12: unlisted indices read zero
        for (int i = 0; i < 64; i++)
            if (!is_listed(i)) begin
                wr(0, i, 32'hDEADBEEF);
                rdchk("R12 unlisted reads zero", 0, i, 0);
            end
        rdchk("R1 other channel untouched", 1, 0, pat(1, 0));

        // R3: configuration forcing
        wr(0, 33, 32'h3);
        chk("R3 cfg 3 -> halted", 32'(chan_state[2:0]), 2);
        rdchk("R3 cfg readback", 0, 33, 32'h3);
        chk("R1 ch1 state unaffected", 32'(chan_state[5:3]), 1);
        wr(0, 33, 32'h1);
        chk("R3 cfg 1 holds halted", 32'(chan_state[2:0]), 2);
        wr(0, 33, 32'h2);
        chk("R3 bit0 clear wins -> reset", 32'(chan_state[2:0]), 1);
        rdchk("R6 status after reset force", 0, 34, stat(1, 0, 1));

        // R4: start gating
        wr(0, 33, 32'h1);
        chk("R4 enabled needs client", 32'(chan_enabled[0]), 0);
        pulse_start(0);
        chk("R4 no client no start", 32'(chan_state[2:0]), 1);
        client_present = 2'b11;
        #1 chk("R4 enabled", 32'(chan_enabled[0]), 1);
        // R5: eol set then cleared by start
        @(negedge clk); eol_set[0] = 1'b1;
        @(negedge clk); eol_set[0] = 1'b0;
        rdchk("R5 eol set", 0, 34, stat(1, 1, 1));
        pulse_start(0);
        chk("R4 start -> active", 32'(chan_state[2:0]), 4);
        rdchk("R5 start clears eol", 0, 34, stat(4, 0, 1));
        wr(0, 33, 32'h3);
        chk("R3 active -> halted", 32'(chan_state[2:0]), 2);
        pulse_start(0);
        chk("R4 halted blocks start", 32'(chan_state[2:0]), 2);
        wr(1, 33, 32'h1);
        pulse_start(1);
        chk("R4 ch1 start", 32'(chan_state[5:3]), 4);
        chk("R1 ch0 unaffected by ch1 start", 32'(chan_state[2:0]), 2);
        // R5: src load, eol+start same cycle
        @(negedge clk); src_load[1] = 1'b1; src_value[7:4] = 4'hA;
        @(negedge clk); src_load[1] = 1'b0;
        rdchk("R6 status src bits", 1, 34, stat(4, 0, 10));
        wr(0, 33, 32'h1);
        @(negedge clk); eol_set[0] = 1'b1; start_req[0] = 1'b1;
        @(negedge clk); eol_set[0] = 1'b0; start_req[0] = 1'b0;
        rdchk("R5 eol wins over start", 0, 34, stat(4, 1, 1));
        // R6: status writes ignored
        wr(1, 34, 32'hFFFFFFFF);
        rdchk("R6 status write ignored", 1, 34, stat(4, 0, 10));

        // R7 R8 R9: sweep mask x set, then acknowledge a derived pattern
        for (int m = 0; m < 16; m++)
            for (int s = 0; s < 16; s++) begin
                logic [3:0] a, rem;
                a = 4'(s ^ m);
                wr(0, 36, 32'hF);
                wr(0, 35, 32'(m));
                pulse_set(0, 4'(s));
                rdchk("R9 raw after set", 0, 37, 32'(s));
                rdchk("R8 masked", 0, 38, 32'(s & m));
                chk("R8 irq level", 32'(irq[0]), 32'((s & m) != 0));
                wr(0, 36, 32'(a));
                rem = 4'(s) & ~a;
                rdchk("R7 ack clears raw", 0, 37, 32'(rem));
                chk("R8 irq after ack", 32'(irq[0]), 32'((rem & 4'(m)) != 0));
            end
        chk("R1 ch1 irq untouched", 32'(irq[1]), 0);
        rdchk("R7 ack reads zero", 0, 36, 0);
        // R7: set wins over same-cycle ack
        wr(0, 36, 32'hF);
        wr(0, 35, 32'hF);
        pulse_set(0, 4'h1);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = mk_addr(0, 36, 0); bus_wdata = 32'h3; intr_set[3:0] = 4'h2;
        @(negedge clk);
        bus_wr = 1'b0; intr_set = '0;
        rdchk("R7 set wins over ack", 0, 37, 32'h2);
        // R9: raw and masked not writable
        wr(0, 37, 32'h0);
        rdchk("R9 raw write ignored", 0, 37, 32'h2);
        wr(0, 38, 32'h0);
        rdchk("R9 masked write ignored", 0, 38, 32'h2);
        chk("R8 irq stays", 32'(irq[0]), 1);
        wr(0, 35, 32'h0);
        chk("R8 mask write drops irq", 32'(irq[0]), 0);

        // R10: stream command
        wr(1, 39, 32'hFFFFFFFF);
        chk("R10 scmd strobe", 32'(scmd_strobe), 32'h2);
        @(negedge clk);
        chk("R10 scmd strobe one cycle", 32'(scmd_strobe), 0);
        rdchk("R10 scmd low 10 bits", 1, 39, 32'h3FF);
        // R11: command
        wr(0, 32, 32'h12345601);
        chk("R11 cmd strobe", 32'(cmd_strobe), 32'h1);
        @(negedge clk);
        chk("R11 cmd strobe one cycle", 32'(cmd_strobe), 0);
        rdchk("R11 cmd readback", 0, 32, 32'h12345601);
        rdchk("R1 ch1 cmd untouched", 1, 32, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule